// File: doc/BRIEF.md
# Set-Associative Data Address Translation Buffer

This block maps a 32-bit virtual data address to a physical address. It looks the address up in a set-associative table of page translations. Each table slot pairs a match word with a translate word. The match word holds the virtual page tag, a valid flag and a small use counter. The translate word holds the physical page number, a cache-inhibit flag and four access-enable flags: read and write, each for user and for supervisor mode. A lookup carries the address, a write flag, a supervisor flag, a translation-enable flag and a unit-present flag. The registered result comes back one clock later. It gives the physical address, a cache-inhibit indication, and hit, miss and page-fault flags.

A lookup can also be raised as a probe. A probe returns the translation without touching the use counters and without ever flagging a miss or a fault. A miss or a refused access returns address zero. A probe updates the cache-inhibit output only when its pass-through-cache flag is set. When translation is off, or the unit is marked absent, the address passes through unchanged. In that case cache inhibit follows the top address bit. Table slots are loaded through a set/way/data write port, and a combinational readback port returns any match word.

Top module: `dtlb_xlate`

## Requirements
- R1: With `xlat_en` low or `mmu_present` low, a lookup returns `rsp_paddr` equal to `lk_vaddr` with hit, miss and fault low. For a non-probe lookup, or a probe with `lk_probe_ci` high, `rsp_ci` equals `lk_vaddr[31]`, so it is high exactly for addresses at or above 0x80000000.
- R2: With translation on, the set index is `lk_vaddr[18:13]` and the compared tag is `lk_vaddr[31:19]`. A way hits only when its stored tag equals that tag and its valid bit is set. The valid bit is match-word bit 0 and the tag is match-word bits 31:19.
- R3: When both ways of a set hit, the higher-numbered way supplies the translation.
- R4: On a non-probe hit with `lk_super` high, a write needs translate-word bit 4 and a read needs bit 3. Without the needed bit, `rsp_fault` is raised together with `rsp_hit`.
- R5: On a non-probe hit with `lk_super` low, a write needs translate-word bit 2 and a read needs bit 1. Without the needed bit, `rsp_fault` is raised together with `rsp_hit`.
- R6: On a hit, `rsp_paddr` is translate-word bits 31:13 followed by `lk_vaddr[12:0]`, and `rsp_ci` is translate-word bit 0.
- R7: On every non-probe hit, each way of the looked-up set with a nonzero use counter (match-word bits 2:1) decrements by one, and the hit way's counter is then set to 3. This happens whether or not the access faults.
- R8: A non-probe lookup with translation on that finds no way raises `rsp_miss`, returns address zero and drives `rsp_ci` low.
- R9: A probe (`lk_probe` high) leaves all use counters unchanged and never raises miss or fault. On a miss or a refused access it returns address zero with `rsp_hit` low. It changes `rsp_ci` only when `lk_probe_ci` is high; otherwise `rsp_ci` keeps its previous value.
- R10: `rsp_valid` is high for exactly the one cycle after each cycle with `lk_req` high. The other response outputs hold between requests.
- R11: Reset clears every valid bit and use counter. After reset, every lookup with translation on misses, and `rsp_valid` and `rsp_ci` are low.
- R12: With `wr_en` high, `wr_sel` low writes the match word and `wr_sel` high writes the translate word of slot (`wr_set`, `wr_way`). `rb_match` returns the tag, use counter and valid bit of slot (`rb_set`, `rb_way`), with bits 18:3 read as zero. A write in the same cycle as a counter update wins for its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | Access is a write |
| lk_super | input | 1 | Access is in supervisor mode |
| xlat_en | input | 1 | Translation enabled |
| mmu_present | input | 1 | Translation unit present |
| lk_probe | input | 1 | Side-effect-free probe lookup |
| lk_probe_ci | input | 1 | Probe passes through cache: update cache inhibit |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 = match word, 1 = translate word |
| wr_set | input | 6 | Set written |
| wr_way | input | 1 | Way written |
| wr_data | input | 32 | Word written |
| rb_set | input | 6 | Readback set |
| rb_way | input | 1 | Readback way |
| rb_match | output | 32 | Match word of the readback slot |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_ci | output | 1 | Cache inhibit |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation miss |
| rsp_fault | output | 1 | Page fault |

## Verification
The bench builds the block with its default parameters: 8 KB pages, 64 sets, 2 ways and a 2-bit use counter. Random tags are drawn from a pool of four values, so a lookup often finds both ways of a set holding the same tag. This exercises the higher-way rule, and misses and valid-bit-clear slots appear in the same run. With only two ways and a four-state counter, the ceiling, the one-step decrement and the floor at zero all show within a couple of hits per set. These are checked through the readback port after directed hit and probe sequences.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  localparam int VA_W   = 32;
  localparam int ATTR_W = 5;

  // Translate-word low bits; positions are visible to software writing the table.
  typedef struct packed {
    logic sup_wr;
    logic sup_rd;
    logic usr_wr;
    logic usr_rd;
    logic ci;
  } perm_t;

  function automatic logic perm_granted(perm_t p, logic is_wr, logic is_sup);
    if (is_sup) return is_wr ? p.sup_wr : p.sup_rd;
    return is_wr ? p.usr_wr : p.usr_rd;
  endfunction

endpackage

// File: rtl/dtlb_store.sv
module dtlb_store
  import dtlb_pkg::*;
#(
  parameter int N_SETS   = 64,
  parameter int N_WAYS   = 2,
  parameter int LRU_W    = 2,
  parameter int TAG_W    = 13,
  parameter int PPN_W    = 19,
  parameter int SET_BITS = 6,
  parameter int WAY_W    = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SET_BITS-1:0]           rd_set,
  output logic [N_WAYS-1:0][TAG_W-1:0]  set_tag,
  output logic [N_WAYS-1:0]             set_vld,
  output logic [N_WAYS-1:0][PPN_W-1:0]  set_ppn,
  output perm_t [N_WAYS-1:0]            set_attr,
  input  logic                          lru_upd,
  input  logic [WAY_W-1:0]              upd_way,
  input  logic                          wr_en,
  input  logic                          wr_sel,
  input  logic [SET_BITS-1:0]           wr_set,
  input  logic [WAY_W-1:0]              wr_way,
  input  logic [VA_W-1:0]               wr_data,
  input  logic [SET_BITS-1:0]           rb_set,
  input  logic [WAY_W-1:0]              rb_way,
  output logic [VA_W-1:0]               rb_match
);

  localparam int PAGE_BITS        = VA_W - PPN_W;
  localparam int MID_W            = VA_W - TAG_W - LRU_W - 1;
  localparam logic [LRU_W-1:0] LRU_MAX = {LRU_W{1'b1}};

  logic [TAG_W-1:0] tag_q  [N_SETS][N_WAYS];
  logic [PPN_W-1:0] ppn_q  [N_SETS][N_WAYS];
  perm_t            attr_q [N_SETS][N_WAYS];
  logic             vld_q  [N_SETS][N_WAYS];
  logic             vld_d  [N_SETS][N_WAYS];
  logic [LRU_W-1:0] lru_q  [N_SETS][N_WAYS];
  logic [LRU_W-1:0] lru_d  [N_SETS][N_WAYS];

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[PAGE_BITS-1:ATTR_W];

  // Next state for valid bits and use counters
  always_comb begin
    vld_d = vld_q;
    lru_d = lru_q;
    if (lru_upd) begin
      for (int w = 0; w < N_WAYS; w++) begin
        if (WAY_W'(w) == upd_way)
          lru_d[rd_set][w] = LRU_MAX;
        else if (lru_q[rd_set][w] != '0)
          lru_d[rd_set][w] = lru_q[rd_set][w] - 1'b1;
      end
    end
    if (wr_en && !wr_sel) begin
      vld_d[wr_set][wr_way] = wr_data[0];
      lru_d[wr_set][wr_way] = wr_data[LRU_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SETS; s++) begin
        for (int w = 0; w < N_WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          lru_q[s][w] <= '0;
        end
      end
    end else begin
      vld_q <= vld_d;
      lru_q <= lru_d;
    end
  end

  // Payload storage: no reset, written only through the table port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (!wr_sel) begin
        tag_q[wr_set][wr_way] <= wr_data[VA_W-1 -: TAG_W];
      end else begin
        ppn_q[wr_set][wr_way]  <= wr_data[VA_W-1 -: PPN_W];
        attr_q[wr_set][wr_way] <= perm_t'(wr_data[ATTR_W-1:0]);
      end
    end
  end

  for (genvar w = 0; w < N_WAYS; w++) begin : g_rd
    assign set_tag[w]  = tag_q[rd_set][w];
    assign set_vld[w]  = vld_q[rd_set][w];
    assign set_ppn[w]  = ppn_q[rd_set][w];
    assign set_attr[w] = attr_q[rd_set][w];
  end

  assign rb_match = {tag_q[rb_set][rb_way], {MID_W{1'b0}},
                     lru_q[rb_set][rb_way], vld_q[rb_set][rb_way]};

  // R7: the updated way reads its ceiling one cycle after a counter update
  p_lru_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lru_upd && !wr_en) |=> (lru_q[$past(rd_set)][$past(upd_way)] == LRU_MAX));

  // R12: a match-word write lands in the addressed valid bit
  p_wr_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (vld_q[$past(wr_set)][$past(wr_way)] == $past(wr_data[0])));

endmodule

// File: rtl/dtlb_match.sv
module dtlb_match #(
  parameter int N_WAYS = 2,
  parameter int TAG_W  = 13,
  parameter int WAY_W  = 1
) (
  input  logic [TAG_W-1:0]              cmp_tag,
  input  logic [N_WAYS-1:0][TAG_W-1:0]  set_tag,
  input  logic [N_WAYS-1:0]             set_vld,
  output logic                          hit,
  output logic [WAY_W-1:0]              hit_way
);

  logic [N_WAYS-1:0] way_eq;

  for (genvar w = 0; w < N_WAYS; w++) begin : g_cmp
    assign way_eq[w] = set_vld[w] && (set_tag[w] == cmp_tag);
  end

  // Ascending scan: the highest matching way is kept
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < N_WAYS; w++) begin
      if (way_eq[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
  import dtlb_pkg::*;
#(
  parameter int PAGE_SIZE = 8192,
  parameter int N_SETS    = 64,
  parameter int N_WAYS    = 2,
  parameter int LRU_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_req,
  input  logic [31:0]          lk_vaddr,
  input  logic                 lk_write,
  input  logic                 lk_super,
  input  logic                 xlat_en,
  input  logic                 mmu_present,
  input  logic                 lk_probe,
  input  logic                 lk_probe_ci,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [$clog2(N_SETS)-1:0] wr_set,
  input  logic [(N_WAYS>1 ? $clog2(N_WAYS) : 1)-1:0] wr_way,
  input  logic [31:0]          wr_data,
  input  logic [$clog2(N_SETS)-1:0] rb_set,
  input  logic [(N_WAYS>1 ? $clog2(N_WAYS) : 1)-1:0] rb_way,
  output logic [31:0]          rb_match,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_paddr,
  output logic                 rsp_ci,
  output logic                 rsp_hit,
  output logic                 rsp_miss,
  output logic                 rsp_fault
);

  localparam int PAGE_BITS = $clog2(PAGE_SIZE);
  localparam int SET_BITS  = $clog2(N_SETS);
  localparam int WAY_W     = (N_WAYS > 1) ? $clog2(N_WAYS) : 1;
  localparam int TAG_W     = VA_W - PAGE_BITS - SET_BITS;
  localparam int PPN_W     = VA_W - PAGE_BITS;

  logic [SET_BITS-1:0]          lk_set;
  logic [TAG_W-1:0]             lk_tag;
  logic [N_WAYS-1:0][TAG_W-1:0] set_tag;
  logic [N_WAYS-1:0]            set_vld;
  logic [N_WAYS-1:0][PPN_W-1:0] set_ppn;
  perm_t [N_WAYS-1:0]           set_attr;
  logic                         way_hit;
  logic [WAY_W-1:0]             hit_way;
  logic                         lru_upd;

  assign lk_set = lk_vaddr[PAGE_BITS +: SET_BITS];
  assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];

  dtlb_store #(
    .N_SETS(N_SETS), .N_WAYS(N_WAYS), .LRU_W(LRU_W), .TAG_W(TAG_W),
    .PPN_W(PPN_W), .SET_BITS(SET_BITS), .WAY_W(WAY_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .rd_set(lk_set),
    .set_tag(set_tag), .set_vld(set_vld), .set_ppn(set_ppn), .set_attr(set_attr),
    .lru_upd(lru_upd), .upd_way(hit_way),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_set(wr_set), .wr_way(wr_way), .wr_data(wr_data),
    .rb_set(rb_set), .rb_way(rb_way), .rb_match(rb_match)
  );

  dtlb_match #(.N_WAYS(N_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) match_i (
    .cmp_tag(lk_tag), .set_tag(set_tag), .set_vld(set_vld),
    .hit(way_hit), .hit_way(hit_way)
  );

  logic             xl_on;
  perm_t            sel_attr;
  logic [VA_W-1:0]  xl_paddr;
  logic             access_ok;

  assign xl_on     = xlat_en && mmu_present;
  assign sel_attr  = set_attr[hit_way];
  assign xl_paddr  = {set_ppn[hit_way], lk_vaddr[PAGE_BITS-1:0]};
  assign access_ok = perm_granted(sel_attr, lk_write, lk_super);
  assign lru_upd   = lk_req && xl_on && !lk_probe && way_hit;

  logic [VA_W-1:0] paddr_d;
  logic            ci_d, hit_d, miss_d, fault_d;

  // Response next state
  always_comb begin
    paddr_d = '0;
    ci_d    = rsp_ci;
    hit_d   = 1'b0;
    miss_d  = 1'b0;
    fault_d = 1'b0;
    if (!xl_on) begin
      paddr_d = lk_vaddr;
      if (!lk_probe || lk_probe_ci) ci_d = lk_vaddr[VA_W-1];
    end else if (!lk_probe) begin
      if (way_hit) begin
        paddr_d = xl_paddr;
        ci_d    = sel_attr.ci;
        hit_d   = 1'b1;
        fault_d = !access_ok;
      end else begin
        ci_d   = 1'b0;
        miss_d = 1'b1;
      end
    end else if (way_hit && access_ok) begin
      paddr_d = xl_paddr;
      hit_d   = 1'b1;
      if (lk_probe_ci) ci_d = sel_attr.ci;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_ci    <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_paddr <= paddr_d;
        rsp_ci    <= ci_d;
        rsp_hit   <= hit_d;
        rsp_miss  <= miss_d;
        rsp_fault <= fault_d;
      end
    end
  end

  p_resp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  p_idle_no_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);

  p_hit_miss_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_miss));

  p_miss_zero_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_paddr == '0 && !rsp_ci));

  p_probe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_probe) |=> (!rsp_miss && !rsp_fault));

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !(xlat_en && mmu_present)) |=>
      (rsp_paddr == $past(lk_vaddr) && !rsp_hit && !rsp_miss && !rsp_fault));

  p_fault_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_hit);

endmodule

// File: tb/dtlb_xlate_tb_top.sv
module dtlb_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req, lk_write, lk_super, xlat_en, mmu_present, lk_probe, lk_probe_ci;
  logic [31:0] lk_vaddr;
  logic        wr_en, wr_sel;
  logic [5:0]  wr_set, rb_set;
  logic [0:0]  wr_way, rb_way;
  logic [31:0] wr_data, rb_match;
  logic        rsp_valid, rsp_ci, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;

  always #5 clk = ~clk;

  dtlb_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_super(lk_super), .xlat_en(xlat_en),
    .mmu_present(mmu_present), .lk_probe(lk_probe), .lk_probe_ci(lk_probe_ci),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_set(wr_set), .wr_way(wr_way), .wr_data(wr_data),
    .rb_set(rb_set), .rb_way(rb_way), .rb_match(rb_match),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_mr [64][2];
  logic [31:0] m_tr [64][2];
  logic        m_ci;

  localparam logic [31:0] MR_MASK = 32'hFFF8_0007;

  function automatic logic [31:0] mkmr(logic [12:0] tag, logic [1:0] lru, logic v);
    return {tag, 16'b0, lru, v};
  endfunction

  function automatic logic [31:0] mktr(logic [18:0] ppn, logic [4:0] attr);
    return {ppn, 8'b0, attr};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tbl_write(logic sel, logic [5:0] s, logic w, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_set = s; wr_way = w; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!sel) m_mr[s][w] = d & MR_MASK;
    else      m_tr[s][w] = d;
  endtask

  task automatic rb_chk(string req, logic [5:0] s, logic w, logic [31:0] mask);
    rb_set = s; rb_way = w;
    #1;
    chk(req, 64'(rb_match & mask), 64'(m_mr[s][w] & mask));
  endtask

  // Expected response from the requirements; updates the model state
  task automatic lookup(string req, logic [31:0] va, bit wr, bit sup, bit en, bit pres,
                        bit prb, bit pci);
    logic [31:0] ep; bit eci, eh, em, ef, ok;
    int s, hw;
    string lbl;
    logic [31:0] tr;
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_write = wr; lk_super = sup;
    xlat_en = en; mmu_present = pres; lk_probe = prb; lk_probe_ci = pci;
    s = int'(va[18:13]);
    ep = '0; eci = m_ci; eh = 0; em = 0; ef = 0; lbl = req;
    if (!(en && pres)) begin
      ep = va;
      if (!prb || pci) eci = va[31];
      if (lbl == "") lbl = "R1";
    end else begin
      hw = -1;
      for (int w = 0; w < 2; w++)
        if (m_mr[s][w][0] && m_mr[s][w][31:19] == va[31:19]) hw = w;
      if (hw < 0) begin
        if (!prb) begin em = 1; eci = 0; end
        if (lbl == "") lbl = prb ? "R9" : "R8";
      end else begin
        tr = m_tr[s][hw];
        ok = sup ? (wr ? tr[4] : tr[3]) : (wr ? tr[2] : tr[1]);
        if (!prb) begin
          eh = 1; ef = !ok; ep = {tr[31:13], va[12:0]}; eci = tr[0];
          for (int w = 0; w < 2; w++) begin
            if (w == hw) m_mr[s][w][2:1] = 2'd3;
            else if (m_mr[s][w][2:1] != 0) m_mr[s][w][2:1] = m_mr[s][w][2:1] - 2'd1;
          end
          if (lbl == "") lbl = ok ? "R6" : (sup ? "R4" : "R5");
        end else begin
          if (ok) begin
            eh = 1; ep = {tr[31:13], va[12:0]};
            if (pci) eci = tr[0];
          end
          if (lbl == "") lbl = "R9";
        end
      end
    end
    m_ci = eci;
    @(negedge clk);
    lk_req = 1'b0;
    chk(lbl, {27'b0, rsp_valid, rsp_paddr, rsp_ci, rsp_hit, rsp_miss, rsp_fault},
             {27'b0, 1'b1, ep, eci, eh, em, ef});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; lk_req = 0; lk_vaddr = 0; lk_write = 0; lk_super = 0;
    xlat_en = 0; mmu_present = 0; lk_probe = 0; lk_probe_ci = 0;
    wr_en = 0; wr_sel = 0; wr_set = 0; wr_way = 0; wr_data = 0; rb_set = 0; rb_way = 0;
    m_ci = 1'b0;
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 2; w++) begin m_mr[s][w] = '0; m_tr[s][w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11", {62'b0, rsp_valid, rsp_ci}, 64'd0);
    rb_chk("R11", 6'd0, 1'b0, 32'h7);
    rb_chk("R11", 6'd63, 1'b1, 32'h7);
    lookup("R11", 32'h0000_2000, 0, 1, 1, 1, 0, 0);

    // R10: valid drops when idle
    @(negedge clk);
    chk("R10", 64'(rsp_valid), 64'd0);

    // R1: pass-through and address-based cache inhibit
    lookup("R1", 32'h7FFF_FFFF, 0, 0, 0, 1, 0, 0);
    lookup("R1", 32'h8000_0000, 1, 0, 1, 0, 0, 0);
    lookup("R9", 32'h1234_5678, 0, 0, 0, 1, 1, 0);
    lookup("R9", 32'h9000_0000, 0, 0, 0, 0, 1, 1);

    // Populate the table at random (R12)
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 2; w++) begin
        tbl_write(1'b0, 6'(s), 1'(w),
                  mkmr(13'($urandom % 4), 2'($urandom), ($urandom % 5) != 0));
        tbl_write(1'b1, 6'(s), 1'(w), mktr(19'($urandom), 5'($urandom)));
      end
    rb_chk("R12", 6'd17, 1'b1, 32'hFFFF_FFFF);

    // R3: duplicate tag in both ways
    tbl_write(1'b0, 6'd5, 1'b0, mkmr(13'd7, 2'd0, 1'b1));
    tbl_write(1'b0, 6'd5, 1'b1, mkmr(13'd7, 2'd0, 1'b1));
    tbl_write(1'b1, 6'd5, 1'b0, mktr(19'h1AAAA, 5'h1F));
    tbl_write(1'b1, 6'd5, 1'b1, mktr(19'h05555, 5'h1E));
    lookup("R3", {13'd7, 6'd5, 13'h0ABC}, 0, 1, 1, 1, 0, 0);

    // R2: tag match but valid clear
    tbl_write(1'b0, 6'd6, 1'b0, mkmr(13'd9, 2'd0, 1'b0));
    tbl_write(1'b0, 6'd6, 1'b1, mkmr(13'd8, 2'd0, 1'b1));
    lookup("R2", {13'd9, 6'd6, 13'h0001}, 0, 0, 1, 1, 0, 0);

    // R7: use counters via readback
    tbl_write(1'b0, 6'd9, 1'b0, mkmr(13'd1, 2'd0, 1'b1));
    tbl_write(1'b0, 6'd9, 1'b1, mkmr(13'd2, 2'd0, 1'b1));
    tbl_write(1'b1, 6'd9, 1'b0, mktr(19'h00100, 5'h1E));
    tbl_write(1'b1, 6'd9, 1'b1, mktr(19'h00200, 5'h1F));
    lookup("R6", {13'd1, 6'd9, 13'h0010}, 0, 0, 1, 1, 0, 0);
    rb_chk("R7", 6'd9, 1'b0, 32'h7);
    rb_chk("R7", 6'd9, 1'b1, 32'h7);
    lookup("R6", {13'd2, 6'd9, 13'h1FFF}, 1, 1, 1, 1, 0, 0);
    rb_chk("R7", 6'd9, 1'b0, 32'h7);
    rb_chk("R7", 6'd9, 1'b1, 32'h7);
    // R9: probe leaves counters alone
    lookup("R9", {13'd1, 6'd9, 13'h0020}, 0, 0, 1, 1, 1, 1);
    rb_chk("R9", 6'd9, 1'b0, 32'h7);
    rb_chk("R9", 6'd9, 1'b1, 32'h7);

    // R4: supervisor-read-only page
    tbl_write(1'b0, 6'd10, 1'b0, mkmr(13'd3, 2'd1, 1'b1));
    tbl_write(1'b0, 6'd10, 1'b1, mkmr(13'd4, 2'd0, 1'b0));
    tbl_write(1'b1, 6'd10, 1'b0, mktr(19'h3C3C3, 5'b01001));
    lookup("R4", {13'd3, 6'd10, 13'h0004}, 0, 1, 1, 1, 0, 0);
    lookup("R4", {13'd3, 6'd10, 13'h0008}, 1, 1, 1, 1, 0, 0);
    lookup("R5", {13'd3, 6'd10, 13'h000C}, 0, 0, 1, 1, 0, 0);
    lookup("R9", {13'd3, 6'd10, 13'h000C}, 1, 1, 1, 1, 1, 1);
    // R5: user-write-only page
    tbl_write(1'b0, 6'd11, 1'b1, mkmr(13'd2, 2'd0, 1'b1));
    tbl_write(1'b0, 6'd11, 1'b0, mkmr(13'd0, 2'd0, 1'b0));
    tbl_write(1'b1, 6'd11, 1'b1, mktr(19'h00777, 5'b00100));
    lookup("R5", {13'd2, 6'd11, 13'h0100}, 1, 0, 1, 1, 0, 0);
    lookup("R5", {13'd2, 6'd11, 13'h0100}, 0, 0, 1, 1, 0, 0);
    lookup("R4", {13'd2, 6'd11, 13'h0100}, 1, 1, 1, 1, 0, 0);
    lookup("R8", {13'd3, 6'd11, 13'h0100}, 0, 0, 1, 1, 0, 0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 10 == 0) begin
        logic sel;
        sel = 1'($urandom);
        tbl_write(sel, 6'($urandom), 1'($urandom),
                  sel ? mktr(19'($urandom), 5'($urandom))
                      : mkmr(13'($urandom % 4), 2'($urandom), ($urandom % 4) != 0));
      end else begin
        logic [31:0] va;
        va = ($urandom % 4 == 0) ? 32'($urandom)
                                 : {13'($urandom % 4), 6'($urandom), 13'($urandom)};
        lookup("", va, 1'($urandom), 1'($urandom), ($urandom % 8) != 0,
               ($urandom % 8) != 0, ($urandom % 4) == 0, 1'($urandom));
      end
    end

    // R12/R7: whole table readback against the model
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 2; w++)
        rb_chk("R12", 6'(s), 1'(w), 32'hFFFF_FFFF);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule